// File: doc/BRIEF.md
# Register Write-Select Decoder

This block turns a host write address into the per-word write strobes of a bank of control registers. Every register has a base word address set by a parameter. A register wider than one bus word takes several consecutive word addresses, and each of those words gets a select line of its own. A single write-accepted flag goes with the strobes. For a register built with a validity input, the flag follows that input. For any other register it is forced high.

When the bank sits inside a larger address space, the address bits above the bank's own span must equal a base constant. If they do not, the bank ignores the access. The decoder is purely combinational and has no clock or reset. Its outputs follow the address and validity inputs within the same time step. Register storage, the read path and bus handshaking are left to the surrounding logic.

Top module: `wsd_decoder`

## Requirements
- R1: An address that matches no register word drives every `wr_sel` bit to 0 and `wr_ok` to 0.
- R2: Only address bits [AREA_LG-1:WORD_LG] select the register word (default bits [7:2]). The byte-offset bits [WORD_LG-1:0] have no effect on `wr_sel` or `wr_ok`.
- R3: Word i of register r sits at word address REG_ADDR[r]+i and drives `wr_sel` bit SUM(REG_WORDS[0..r-1])+i. With the defaults, bit 0 is register 0, bits 1-2 are register 1, bit 3 is register 2 and bits 4-6 are register 3, at word addresses 0, 2-3, 5 and 8-10.
- R4: At most one `wr_sel` bit is high at any time, and exactly one is high for every mapped word address.
- R5: A match on a register built without a validity input sets `wr_ok` to 1, whatever its `reg_valid` bit holds. With the defaults these are registers 0 and 3.
- R6: A match on a register built with a validity input sets `wr_ok` equal to that register's `reg_valid` bit, while its select bit still goes high. With the defaults these are registers 1 and 2.
- R7: With NESTED set, address bits [ADDR_W-1:AREA_LG] must equal AREA_BASE (default 4'h3 on bits [11:8]). On a mismatch every `wr_sel` bit is 0 and `wr_ok` is 0.
- R8: The outputs depend only on the present inputs, and a new address is fully decoded without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| host_wr_addr | input | ADDR_W | Host write byte address |
| reg_valid | input | NUM_REGS | Per-register validity, used only by registers built with one |
| wr_sel | output | TOTAL_WORDS | One write strobe per register word |
| wr_ok | output | 1 | Write accepted by the register bank |

## Verification
Every word address of the bank is swept with all validity bits high. The sweep separates mapped words from holes between registers and shows whether each multi-word register maps its words to the right select bits. Byte offsets inside one word check that the low address bits are ignored. Validity toggling tells the registers that follow their validity input apart from those that ignore it. Foreign upper address bits, paired with an otherwise mapped word offset, show that the area gate overrides a word match.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

  function automatic int unsigned wsd_clog2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/wsd_area_gate.sv
module wsd_area_gate #(
  parameter int unsigned  HI_W   = 4,
  parameter bit           NESTED = 1'b1,
  parameter logic [HI_W-1:0] BASE = '0
) (
  input  logic [HI_W-1:0] addr_hi,
  output logic            area_hit
);

  generate
    if (NESTED) begin : g_nested
      assign area_hit = (addr_hi == BASE);
    end else begin : g_flat
      logic unused_hi;
      assign unused_hi = ^addr_hi;
      assign area_hit  = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/wsd_reg_slot.sv
module wsd_reg_slot #(
  parameter int unsigned WORDS = 1,
  parameter int unsigned WADDR = 0,
  parameter int unsigned CMP_W = 6,
  parameter bit          HAS_V = 1'b0
) (
  input  logic [CMP_W-1:0] word_addr,
  input  logic             enable,
  input  logic             valid,
  output logic [WORDS-1:0] sel,
  output logic             hit,
  output logic             ok
);

  genvar gi;
  generate
    for (gi = 0; gi < WORDS; gi++) begin : g_word
      localparam logic [CMP_W-1:0] MATCH = CMP_W'(WADDR + gi);
      assign sel[gi] = enable && (word_addr == MATCH);
    end
  endgenerate

  assign hit = |sel;
  assign ok  = hit & (HAS_V ? valid : 1'b1);

  always_comb begin
    if (!HAS_V && (sel != '0))
      p_plain_ok_r5: assert (ok);
    if (!enable)
      p_disabled_quiet_r7: assert (sel == '0 && !ok);
  end

endmodule

// File: rtl/wsd_decoder.sv
module wsd_decoder
  import wsd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned AREA_BYTES = 256,
  parameter bit          NESTED     = 1'b1,
  parameter int unsigned AREA_BASE  = 3,
  parameter int unsigned NUM_REGS   = 4,
  parameter int unsigned REG_WORDS [NUM_REGS] = '{1, 2, 1, 3},
  parameter int unsigned REG_ADDR  [NUM_REGS] = '{0, 2, 5, 8},
  parameter logic [NUM_REGS-1:0] HAS_VALID = 4'b0110
) (
  input  logic [ADDR_W-1:0]      host_wr_addr,
  input  logic [NUM_REGS-1:0]    reg_valid,
  output logic [TOTAL_WORDS-1:0] wr_sel,
  output logic                   wr_ok
);

  function automatic int unsigned sel_base(input int unsigned r);
    int unsigned s;
    s = 0;
    for (int unsigned k = 0; k < r; k++) s += REG_WORDS[k];
    return s;
  endfunction

  localparam int unsigned WORD_LG     = wsd_clog2(WORD_BYTES);
  localparam int unsigned AREA_LG     = wsd_clog2(AREA_BYTES);
  localparam int unsigned CMP_W       = AREA_LG - WORD_LG;
  localparam int unsigned HI_W        = ADDR_W - AREA_LG;
  localparam int unsigned TOTAL_WORDS = sel_base(NUM_REGS);

  logic                 unused_lo;
  logic                 area_hit;
  logic [CMP_W-1:0]     word_addr;
  logic [NUM_REGS-1:0]  slot_hit;
  logic [NUM_REGS-1:0]  slot_ok;

  assign unused_lo = ^host_wr_addr[WORD_LG-1:0];
  assign word_addr = host_wr_addr[AREA_LG-1:WORD_LG];

  wsd_area_gate #(
    .HI_W   (HI_W),
    .NESTED (NESTED),
    .BASE   (HI_W'(AREA_BASE))
  ) u_gate (
    .addr_hi  (host_wr_addr[ADDR_W-1:AREA_LG]),
    .area_hit (area_hit)
  );

  genvar gr;
  generate
    for (gr = 0; gr < NUM_REGS; gr++) begin : g_reg
      localparam int unsigned LO = sel_base(gr);
      localparam int unsigned NW = REG_WORDS[gr];
      wsd_reg_slot #(
        .WORDS (NW),
        .WADDR (REG_ADDR[gr]),
        .CMP_W (CMP_W),
        .HAS_V (HAS_VALID[gr])
      ) u_slot (
        .word_addr (word_addr),
        .enable    (area_hit),
        .valid     (reg_valid[gr]),
        .sel       (wr_sel[LO +: NW]),
        .hit       (slot_hit[gr]),
        .ok        (slot_ok[gr])
      );
    end
  endgenerate

  assign wr_ok = |slot_ok;

  always_comb begin
    p_single_sel_r4: assert ($onehot0(wr_sel));
    p_one_slot_r4: assert ($onehot0(slot_hit));
    if (wr_ok)
      p_ok_has_sel_r6: assert (wr_sel != '0);
    if (wr_sel == '0)
      p_idle_no_ok_r1: assert (!wr_ok);
    if (!area_hit)
      p_gate_blocks_r7: assert (wr_sel == '0 && !wr_ok);
  end

endmodule

// File: tb/sim_wsd_decoder.sv
module sim_wsd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 4;
  localparam int NSEL  = 7;
  localparam logic [3:0] BASE = 4'h3;

  logic            clk;
  logic            rst;
  logic [11:0]     addr;
  logic [NREG-1:0] valid;
  logic [NSEL-1:0] sel;
  logic            ok;

  int n_checks;
  int n_fail;
  bit done;

  wsd_decoder u0 (
    .host_wr_addr (addr),
    .reg_valid    (valid),
    .wr_sel       (sel),
    .wr_ok        (ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Independent expected map: register words, base words, validity use
  int t_words [NREG] = '{1, 2, 1, 3};
  int t_addr  [NREG] = '{0, 2, 5, 8};
  bit t_hasv  [NREG] = '{0, 1, 1, 0};

  function automatic logic [11:0] mk(input logic [3:0] hi, input int w, input int off);
    return {hi, 6'(w), 2'(off)};
  endfunction

  task automatic expect_for(input logic [3:0] hi, input int w, input logic [NREG-1:0] v,
                            output logic [NSEL-1:0] es, output logic eo);
    int bitpos;
    es = '0;
    eo = 1'b0;
    bitpos = 0;
    if (hi == BASE) begin
      for (int r = 0; r < NREG; r++) begin
        for (int i = 0; i < t_words[r]; i++) begin
          if (w == t_addr[r] + i) begin
            es[bitpos + i] = 1'b1;
            eo = t_hasv[r] ? v[r] : 1'b1;
          end
        end
        bitpos += t_words[r];
      end
    end
  endtask

  task automatic check(input bit cond, input string req, input logic [NSEL-1:0] a_sel,
                       input logic a_ok, input logic [NSEL-1:0] e_sel, input logic e_ok);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s addr=%h sel=%b ok=%b expected sel=%b ok=%b",
               req, addr, a_sel, a_ok, e_sel, e_ok);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic [NREG-1:0] v);
    @(posedge clk);
    addr  = a;
    valid = v;
    @(negedge clk);
  endtask

  task automatic cmp(input string req, input logic [3:0] hi, input int w);
    logic [NSEL-1:0] es;
    logic eo;
    expect_for(hi, w, valid, es, eo);
    check(sel == es && ok == eo, req, sel, ok, es, eo);
  endtask

  // R1: reset state with unmapped address
  task automatic t_idle();
    apply(mk(BASE, 1, 0), 4'hF);
    check(sel == '0 && ok == 1'b0, "R1 hole at word 1", sel, ok, '0, 1'b0);
    apply(mk(BASE, 63, 0), 4'hF);
    check(sel == '0 && ok == 1'b0, "R1 top word", sel, ok, '0, 1'b0);
  endtask

  // R3, R4: sweep every word of the area
  task automatic t_sweep();
    int mapped;
    for (int w = 0; w < 64; w++) begin
      apply(mk(BASE, w, 0), 4'hF);
      cmp("R3 sweep", BASE, w);
      mapped = (w == 0 || w == 2 || w == 3 || w == 5 || (w >= 8 && w <= 10)) ? 1 : 0;
      check($countones(sel) == mapped, "R4 onehot", sel, ok, '0, 1'(mapped));
    end
    apply(mk(BASE, 9, 0), 4'hF);
    check(sel == 7'b0100000, "R3 reg3 middle word", sel, ok, 7'b0100000, 1'b1);
    apply(mk(BASE, 3, 0), 4'hF);
    check(sel == 7'b0000100, "R3 reg1 upper word", sel, ok, 7'b0000100, 1'b1);
  endtask

  // R2: byte offset bits ignored
  task automatic t_offset();
    for (int off = 1; off < 4; off++) begin
      apply(mk(BASE, 10, off), 4'hF);
      check(sel == 7'b1000000 && ok, "R2 offset reg3", sel, ok, 7'b1000000, 1'b1);
      apply(mk(BASE, 4, off), 4'hF);
      check(sel == '0 && !ok, "R2 offset hole", sel, ok, '0, 1'b0);
    end
  endtask

  // R5, R6: validity handling
  task automatic t_valid();
    apply(mk(BASE, 2, 0), 4'b1101);
    check(sel == 7'b0000010 && ok == 1'b0, "R6 reg1 invalid", sel, ok, 7'b0000010, 1'b0);
    apply(mk(BASE, 2, 0), 4'b0010);
    check(sel == 7'b0000010 && ok == 1'b1, "R6 reg1 valid", sel, ok, 7'b0000010, 1'b1);
    apply(mk(BASE, 5, 0), 4'b1011);
    check(sel == 7'b0001000 && ok == 1'b0, "R6 reg2 invalid", sel, ok, 7'b0001000, 1'b0);
    apply(mk(BASE, 0, 0), 4'b0000);
    check(sel == 7'b0000001 && ok == 1'b1, "R5 reg0 ignores valid", sel, ok, 7'b0000001, 1'b1);
    apply(mk(BASE, 8, 0), 4'b0000);
    check(sel == 7'b0010000 && ok == 1'b1, "R5 reg3 ignores valid", sel, ok, 7'b0010000, 1'b1);
  endtask

  // R7: area gate
  task automatic t_outside();
    apply(mk(4'h2, 0, 0), 4'hF);
    check(sel == '0 && !ok, "R7 base minus one", sel, ok, '0, 1'b0);
    apply(mk(4'hF, 9, 0), 4'hF);
    check(sel == '0 && !ok, "R7 base far", sel, ok, '0, 1'b0);
    apply(mk(4'h7, 5, 0), 4'hF);
    check(sel == '0 && !ok, "R7 one bit off", sel, ok, '0, 1'b0);
  endtask

  // R8: decode follows address without waiting for a clock edge
  task automatic t_comb();
    @(negedge clk);
    addr = mk(BASE, 10, 0);
    valid = 4'hF;
    #1;
    check(sel == 7'b1000000 && ok, "R8 settles between edges", sel, ok, 7'b1000000, 1'b1);
    addr = mk(BASE, 1, 0);
    #1;
    check(sel == '0 && !ok, "R8 drops between edges", sel, ok, '0, 1'b0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst      = 1'b1;
    addr     = '0;
    valid    = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_sweep();
    t_offset();
    t_valid();
    t_outside();
    t_comb();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule